// File: doc/BRIEF.md
# Multi-Channel Edge-Aligned PWM Timer

This block is a timer that drives several pulse-width modulated outputs from one shared 16-bit up-counter. The counter advances once per prescaler tick. The prescaler divides the system clock by a power of two between 1 and 128. The counter runs from zero up to a programmable modulo value, including that value, and then returns to zero. Each channel compares the counter against its own compare value. Its output is in the active state from the wrap until the count reaches the compare value. A channel control field picks a high-true pulse, a low-true pulse, or no output.

Software reaches the block through a flat 32-bit register interface. It writes in a single cycle, and the read data follows the address combinationally. The modulo and the compare values are double-buffered. While the counter runs, a new period or duty takes effect only at the next wrap, so no shortened or stretched pulse is ever produced. While the counter is stopped, written values apply at once. The number of channels is a parameter and defaults to two.

Top module: `mcpwm_timer`

## Requirements
- R1: After reset, every register reads 0, the counter is stopped at 0 and every PWM output is 0.
- R2: Register byte addresses: timer control 0x10, counter 0x14, modulo 0x18. Channel n has its control register at 0x20+8n and its compare value at 0x24+8n. Any other address, 0x08 included, reads 0, and writes to it change nothing.
- R3: Timer control bits 4:3 hold the clock mode. The counter advances only when this field is 01. The values 00, 10 and 11 hold the counter at its current value.
- R4: Timer control bits 2:0 hold a code k. While the counter runs, it advances once every 2^k clock cycles. After a start with a freshly cleared divider, the first advance comes 2^k cycles after the first running cycle.
- R5: While running, the counter steps by one per tick up to the active modulo value, inclusive. On the following tick it returns to 0.
- R6: Any write to the counter register clears it to 0 on the next clock edge, whatever data is written.
- R7: Writes to the modulo and compare registers read back at once. The counter and outputs use them only from the next wrap while the counter runs, or from the next clock edge while it is stopped.
- R8: Channel control bits 5:4 must be 10 and bits 3:2 must be 10 or 01 for the channel to drive its pulse. Any other setting holds that output at 0.
- R9: With bits 3:2 = 10, the output is 1 while count < compare; with 01 it is the inverse. A compare of 0 therefore gives 0% duty, and a compare above the modulo gives 100% duty.
- R10: Timer control bit 5 (center-aligned counting) is not implemented. It reads back 0, and writing 1 to it leaves counting up-only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW (8) | Register byte address |
| bus_wen | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for bus_addr, combinational |
| pwm_out | output | NUM_CH (2) | One PWM output per channel, bit n = channel n |

## Verification
A register write is captured on the clock edge that ends its bus cycle. A read returns the register contents in the same cycle. The counter and all outputs are combinational on registered state, so a write changes pwm_out and the counter read value from the next cycle onward. When a change is buffered until a wrap, the effect instead appears in the first cycle after the wrap edge. The bench drives one bus operation per cycle and computes the expected counter value and both output bits for each cycle index from these latencies. It compares them half a cycle later, so every buffered change, stop, clear and prescaler step is checked in the exact cycle it is due.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;

  localparam int CNT_W = 16;
  localparam int PS_W  = 3;
  localparam int DIV_W = (1 << PS_W) - 1;

  localparam int ADR_CTRL   = 'h10;
  localparam int ADR_CNT    = 'h14;
  localparam int ADR_MOD    = 'h18;
  localparam int ADR_CH0    = 'h20;
  localparam int CH_STRIDE  = 8;
  localparam int CH_VAL_OFS = 4;

  typedef enum logic [1:0] {
    CLK_STOP = 2'b00,
    CLK_RUN  = 2'b01,
    CLK_RSV2 = 2'b10,
    CLK_RSV3 = 2'b11
  } clk_mode_e;

  typedef enum logic [1:0] {
    SENSE_NONE = 2'b00,
    SENSE_LOW  = 2'b01,
    SENSE_HIGH = 2'b10,
    SENSE_RSV  = 2'b11
  } sense_e;

  localparam logic [1:0] MODE_EDGE = 2'b10;

  typedef struct packed {
    logic [1:0] mode;
    sense_e     sense;
  } ch_ctrl_t;

  typedef struct packed {
    clk_mode_e       clk_mode;
    logic [PS_W-1:0] ps_code;
  } tmr_ctrl_t;

  // low k bits set: the divider must show all ones there for a tick
  function automatic logic [DIV_W-1:0] ps_mask(input logic [PS_W-1:0] code);
    return (DIV_W'(1) << code) - DIV_W'(1);
  endfunction

  function automatic logic ch_active(input ch_ctrl_t c);
    return (c.mode == MODE_EDGE) && (c.sense == SENSE_HIGH || c.sense == SENSE_LOW);
  endfunction

  function automatic logic ch_level(input ch_ctrl_t c, input logic [CNT_W-1:0] cnt,
                                    input logic [CNT_W-1:0] cv);
    logic below;
    below = (cnt < cv);
    if (!ch_active(c)) return 1'b0;
    return (c.sense == SENSE_HIGH) ? below : !below;
  endfunction

endpackage

// File: rtl/mcpwm_prescaler.sv
module mcpwm_prescaler
  import mcpwm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PS_W-1:0] code,
  output logic            tick
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  assign mask = ps_mask(code);
  assign tick = run && ((div_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    div_q <= '0;
    else if (!run) div_q <= '0;
    else           div_q <= div_q + DIV_W'(1);
  end

endmodule

// File: rtl/mcpwm_counter.sv
module mcpwm_counter
  import mcpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] mod_pend,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] mod_act,
  output logic             wrap,
  output logic             load
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mod_q;

  // >= also covers a count left above a modulo shrunk while stopped
  assign wrap    = run && tick && (cnt_q >= mod_q);
  assign load    = !run || wrap;
  assign cnt     = cnt_q;
  assign mod_act = mod_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mod_q <= '0;
    end else begin
      if (clr)              cnt_q <= '0;
      else if (run && tick) cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
      if (load)             mod_q <= mod_pend;
    end
  end

endmodule

// File: rtl/mcpwm_channel.sv
module mcpwm_channel
  import mcpwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] cv_pend,
  input  ch_ctrl_t         ctrl,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cv_act,
  output logic             en,
  output logic             hi,
  output logic             pwm
);

  logic [CNT_W-1:0] cv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cv_q <= '0;
    else if (load) cv_q <= cv_pend;
  end

  assign cv_act = cv_q;
  assign en     = ch_active(ctrl);
  assign hi     = (ctrl.sense == SENSE_HIGH);
  assign pwm    = ch_level(ctrl, cnt, cv_q);

endmodule

// File: rtl/mcpwm_timer.sv
module mcpwm_timer
  import mcpwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int AW     = 8,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wen,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);

  localparam int CTRL_W = 2 + PS_W;

  tmr_ctrl_t                          ctrl_q;
  logic [CNT_W-1:0]                   mod_pend_q;
  ch_ctrl_t [NUM_CH-1:0]              ch_ctrl_q;
  logic [NUM_CH-1:0][CNT_W-1:0]       cv_pend_q;
  logic [NUM_CH-1:0][CNT_W-1:0]       cv_act;
  logic [NUM_CH-1:0]                  ch_en;
  logic [NUM_CH-1:0]                  ch_hi;

  // named internal events, also watched by the checker
  logic             run;
  logic             tick;
  logic             wrap;
  logic             load;
  logic             cnt_wr;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mod_act;
  logic [DW-1:0]    rdata;
  logic             unused_wbits;

  function automatic logic [AW-1:0] ch_adr(input int idx, input logic vsel);
    return AW'(ADR_CH0 + CH_STRIDE * idx + (vsel ? CH_VAL_OFS : 0));
  endfunction

  assign run          = (ctrl_q.clk_mode == CLK_RUN);
  assign cnt_wr       = bus_wen && (bus_addr == AW'(ADR_CNT));
  assign unused_wbits = ^bus_wdata[DW-1:CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      mod_pend_q <= '0;
    end else if (bus_wen) begin
      if (bus_addr == AW'(ADR_CTRL)) begin
        ctrl_q.clk_mode <= clk_mode_e'(bus_wdata[4:3]);
        ctrl_q.ps_code  <= bus_wdata[PS_W-1:0];
      end
      if (bus_addr == AW'(ADR_MOD)) mod_pend_q <= bus_wdata[CNT_W-1:0];
    end
  end

  mcpwm_prescaler u_ps (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .code  (ctrl_q.ps_code),
    .tick  (tick)
  );

  mcpwm_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .tick     (tick),
    .clr      (cnt_wr),
    .mod_pend (mod_pend_q),
    .cnt      (cnt),
    .mod_act  (mod_act),
    .wrap     (wrap),
    .load     (load)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch_ctrl_q[g] <= '0;
        cv_pend_q[g] <= '0;
      end else if (bus_wen) begin
        if (bus_addr == ch_adr(g, 1'b0)) begin
          ch_ctrl_q[g].mode  <= bus_wdata[5:4];
          ch_ctrl_q[g].sense <= sense_e'(bus_wdata[3:2]);
        end
        if (bus_addr == ch_adr(g, 1'b1)) cv_pend_q[g] <= bus_wdata[CNT_W-1:0];
      end
    end

    mcpwm_channel u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .cv_pend (cv_pend_q[g]),
      .ctrl    (ch_ctrl_q[g]),
      .cnt     (cnt),
      .cv_act  (cv_act[g]),
      .en      (ch_en[g]),
      .hi      (ch_hi[g]),
      .pwm     (pwm_out[g])
    );
  end

  always_comb begin
    rdata = '0;
    if (bus_addr == AW'(ADR_CTRL)) rdata = DW'(CTRL_W'({ctrl_q.clk_mode, ctrl_q.ps_code}));
    if (bus_addr == AW'(ADR_CNT))  rdata = DW'(cnt);
    if (bus_addr == AW'(ADR_MOD))  rdata = DW'(mod_pend_q);
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == ch_adr(i, 1'b0)) rdata = DW'({ch_ctrl_q[i], 2'b00});
      if (bus_addr == ch_adr(i, 1'b1)) rdata = DW'(cv_pend_q[i]);
    end
  end

  assign bus_rdata = rdata;

endmodule

// File: rtl/mcpwm_checker.sv
module mcpwm_checker
  import mcpwm_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         run,
  input logic                         tick,
  input logic                         wrap,
  input logic                         cnt_wr,
  input logic [CNT_W-1:0]             cnt,
  input logic [CNT_W-1:0]             mod_act,
  input logic [NUM_CH-1:0][CNT_W-1:0] cv_act,
  input logic [NUM_CH-1:0]            ch_en,
  input logic [NUM_CH-1:0]            ch_hi,
  input logic [NUM_CH-1:0]            pwm_out
);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !cnt_wr) |=> (cnt <= mod_act)); // R5

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !cnt_wr && (cnt < mod_act)) |=> (cnt == $past(cnt) + CNT_W'(1))); // R5

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt)); // R3

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == '0)); // R6

  AST_MOD_BUFFERED: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap) |=> $stable(mod_act)); // R7

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en[g] && (cv_act[g] == '0)) |-> (pwm_out[g] == !ch_hi[g])); // R9

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[g] |-> !pwm_out[g]); // R8

    AST_CV_BUFFERED: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !wrap) |=> $stable(cv_act[g])); // R7
  end

endmodule

bind mcpwm_timer mcpwm_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .run     (run),
  .tick    (tick),
  .wrap    (wrap),
  .cnt_wr  (cnt_wr),
  .cnt     (cnt),
  .mod_act (mod_act),
  .cv_act  (cv_act),
  .ch_en   (ch_en),
  .ch_hi   (ch_hi),
  .pwm_out (pwm_out)
);

// File: tb/test_mcpwm_timer.sv
`timescale 1ns/1ps
module test_mcpwm_timer;

  localparam int NCH = 2;
  localparam logic [7:0] A_GLB  = 8'h08;
  localparam logic [7:0] A_CTRL = 8'h10;
  localparam logic [7:0] A_CNT  = 8'h14;
  localparam logic [7:0] A_MOD  = 8'h18;
  localparam logic [7:0] A_C0C  = 8'h20;
  localparam logic [7:0] A_C0V  = 8'h24;
  localparam logic [7:0] A_C1C  = 8'h28;
  localparam logic [7:0] A_C1V  = 8'h2C;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [7:0]     bus_addr = '0;
  logic           bus_wen = 1'b0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [NCH-1:0] pwm_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // scoreboard queues, one entry per bus cycle
  string          q_req[$];
  bit             q_chk[$];
  logic [31:0]    q_rd[$];
  logic [NCH-1:0] q_pwm[$];

  always #2.5 clk = ~clk;

  mcpwm_timer #(.NUM_CH(NCH)) i_mcpwm_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wen   (bus_wen),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out)
  );

  // monitor: compare at the falling edge of the cycle the item was driven in
  always @(negedge clk) begin
    if (q_req.size() > 0) begin
      string          r;
      bit             c;
      logic [31:0]    e;
      logic [NCH-1:0] p;
      r = q_req.pop_front();
      c = q_chk.pop_front();
      e = q_rd.pop_front();
      p = q_pwm.pop_front();
      if (c) begin
        n_cmp++;
        if (bus_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: rdata=%h expected %h", r, bus_rdata, e);
        end
      end
      n_cmp++;
      if (pwm_out !== p) begin
        n_bad++;
        $display("FAIL %s: pwm_out=%b expected %b", r, pwm_out, p);
      end
    end
  end

  // driver: one bus cycle, pushes what the monitor must see in it
  task automatic step(input bit we, input logic [7:0] a, input logic [31:0] wd,
                      input bit chk, input logic [31:0] er, input logic [NCH-1:0] ep,
                      input string req);
    bus_wen   = we;
    bus_addr  = a;
    bus_wdata = wd;
    q_req.push_back(req);
    q_chk.push_back(chk);
    q_rd.push_back(er);
    q_pwm.push_back(ep);
    @(posedge clk);
    #1;
    bus_wen = 1'b0;
  endtask

  // expected counter value in loop cycle k, derived from the script below
  function automatic int ecnt(input int k);
    int kk;
    if (k < 20) return k % 10;          // modulo 9
    if (k < 42) return (k - 20) % 6;    // modulo 5 from the wrap at k=20
    if (k < 47) return 4;               // stopped
    if (k < 51) return 0;               // cleared
    kk = (k > 80) ? 80 : k;             // divide by 4, stopped again after k=80
    return ((kk - 51) / 4) % 6;
  endfunction

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: run incomplete, expected finish");
      report();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    step(0, A_CTRL, 0, 1, 32'h0, 2'b00, "R1 ctrl");
    step(0, A_CNT,  0, 1, 32'h0, 2'b00, "R1 cnt");
    step(0, A_MOD,  0, 1, 32'h0, 2'b00, "R1 mod");
    step(0, A_C0C,  0, 1, 32'h0, 2'b00, "R1 ch0 ctrl");
    step(0, A_C1V,  0, 1, 32'h0, 2'b00, "R1 ch1 value");

    // configure while stopped: values apply at the next edge (R7)
    step(1, A_MOD, 32'd9,    0, 0, 2'b00, "R7 mod");
    step(1, A_C0V, 32'd4,    0, 0, 2'b00, "R7 cv0");
    step(1, A_C0C, 32'h28,   0, 0, 2'b00, "R8 ch0 high-true");
    step(1, A_C1V, 32'd7,    0, 0, 2'b01, "R7 cv1");
    step(1, A_C1C, 32'h24,   0, 0, 2'b01, "R8 ch1 low-true");
    step(0, A_MOD, 0,        1, 32'd9, 2'b01, "R7 mod readback");
    step(0, A_CNT, 0,        1, 32'd0, 2'b01, "R3 stopped");
    step(0, A_CNT, 0,        1, 32'd0, 2'b01, "R3 stopped");
    step(1, A_CTRL, 32'h08,  0, 0, 2'b01, "R3 start");

    for (int k = 0; k < 88; k++) begin
      int             c;
      int             cv0;
      logic [NCH-1:0] ep;
      string          rq;
      c   = ecnt(k);
      cv0 = (k < 20) ? 4 : ((k < 75) ? 2 : 0);
      ep[1] = !(c < 7);                              // R9 low-true, cv1 above modulo 5 later
      if (k < 82)      ep[0] = (c < cv0);            // R9 high-true
      else if (k < 84) ep[0] = 1'b1;                 // R9 low-true with compare 0
      else             ep[0] = 1'b0;                 // R8 mode 00
      rq = (k < 20) ? "R5 count" : (k < 42) ? "R7 count" : (k < 51) ? "R6 count" : "R4 count";
      case (k)
        12: step(1, A_MOD,  32'd5,     0, 0, ep, "R7 mod write");
        13: step(1, A_C0V,  32'd2,     0, 0, ep, "R7 cv0 write");
        30: step(0, A_MOD,  0,         1, 32'd5, ep, "R7 mod readback");
        41: step(1, A_CTRL, 32'h00,    0, 0, ep, "R3 stop");
        46: step(1, A_CNT,  32'hBEEF,  0, 0, ep, "R6 clear");
        50: step(1, A_CTRL, 32'h0A,    0, 0, ep, "R4 divide by 4");
        52: step(1, A_C0V,  32'd0,     0, 0, ep, "R9 cv0 zero");
        73: step(1, A_CTRL, 32'h2A,    0, 0, ep, "R10 center bit");
        74: step(0, A_CTRL, 0,         1, 32'h0A, ep, "R10 readback");
        75: step(1, A_GLB,  32'hFFFF,  0, 0, ep, "R2 unmapped write");
        76: step(0, A_GLB,  0,         1, 32'h0, ep, "R2 unmapped read");
        77: step(0, A_C1V,  0,         1, 32'd7, ep, "R2 ch1 value");
        78: step(0, A_C1C,  0,         1, 32'h24, ep, "R2 ch1 ctrl");
        79: step(1, A_CTRL, 32'h12,    0, 0, ep, "R3 mode 10 stops");
        81: step(1, A_C0C,  32'h24,    0, 0, ep, "R9 ch0 low-true");
        83: step(1, A_C0C,  32'h04,    0, 0, ep, "R8 ch0 mode off");
        default: step(0, A_CNT, 0,     1, 32'(c), ep, rq);
      endcase
    end

    while (q_req.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    report();
    $finish;
  end

endmodule